// File: doc/BRIEF.md
# Circular Sampler Stop and Region-of-Interest Readout

This block is the digital controller of a circular sampling memory. A write position walks a ring of cells once per sample-enable cycle and wraps around without end, so the ring always holds the most recent history. Eight channels of 1024 cells each can be joined into longer rings. The cascade setting gives eight rings of 1024 cells, four of 2048, two of 4096, or a single ring of 8192 cells. All rings share one write position, and in a joined ring a cell index above 1023 simply lies in the next channel.

A trigger does not freeze the ring at once. The ring keeps sampling for a programmed number of further sample-enable cycles, then stops, and the cell it stopped on is latched as the stop cell. The block then emits a run of cell addresses, one per readout tick. The run starts at the stop cell, wraps modulo the ring length, and covers only the requested region-of-interest length, so dead time scales with that length and not with the full depth of the ring. The busy flag spans the whole dead period. After readout an arm pulse resumes sampling from where the ring stopped.

Top module: `roi_sampler`

## Requirements
- R1: After reset busy, rd_vld and stop_cell are all 0 and the write position is cell 0.
- R2: casc_mode value m (0..3) sets the ring length to 1024<<m cells. The write position steps to (pos+1) mod ring length on every sampling cycle with smp_en high.
- R3: A trig seen while sampling raises busy from the next cycle. That cycle's sample still advances the ring. The ring then advances on exactly trig_dly further smp_en cycles and stops on the following clock edge, where stop_cell takes the write position.
- R4: stop_cell changes only when the ring stops and keeps its value through readout, after readout and after arm.
- R5: During readout each rd_tick gives one rd_vld cycle, one clock later, with rd_addr = (stop_cell + k) mod ring length for the k-th cell (k from 0). When rd_tick is low, rd_vld is low.
- R6: A roi_len of 0 or larger than the ring length reads the whole ring. Any other value reads exactly roi_len cells.
- R7: rd_vld is high only while busy is high. busy falls on the cycle after the last region cell is output.
- R8: trig is ignored while busy and while stopped after readout. rd_tick is ignored outside readout.
- R9: arm after readout resumes sampling from the stop position. arm at any other time has no effect.
- R10: The write position does not move while the ring is stopped, whatever smp_en does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sampling step enable |
| trig | input | 1 | Trigger request |
| arm | input | 1 | Resume sampling after readout |
| casc_mode | input | 2 | Channel joining: ring length 1024<<m |
| trig_dly | input | 10 | Sampling cycles kept after trigger |
| roi_len | input | 14 | Cells to read (0 means full ring) |
| rd_tick | input | 1 | Readout step enable |
| stop_cell | output | 13 | Cell where the ring stopped |
| rd_addr | output | 13 | Cell address being read |
| rd_vld | output | 1 | rd_addr holds a region cell |
| busy | output | 1 | Dead time: trigger delay plus readout |

## Verification
The assertions assume that casc_mode stays fixed from a trigger until readout ends, because the address range check compares against the ring length captured at the stop. They also assume that a new region length takes effect only at a stop. The stimulus changes casc_mode, trig_dly and roi_len only at the start of an event, while the ring is sampling. It keeps those inputs steady until arm, and it exercises trig, arm, smp_en and rd_tick at random in every phase.

// File: rtl/roi_pkg.sv
package roi_pkg;

  typedef enum logic [1:0] {
    ST_SAMPLE = 2'd0,
    ST_DELAY  = 2'd1,
    ST_DRAIN  = 2'd2,
    ST_PARKED = 2'd3
  } roi_state_e;

  // length of one joined ring
  function automatic logic [31:0] ring_cells(input logic [31:0] base, input logic [1:0] mode);
    return base << mode;
  endfunction

  // zero or oversize request reads the full ring
  function automatic logic [31:0] roi_clamp(input logic [31:0] req, input logic [31:0] ring);
    return (req == 32'd0 || req > ring) ? ring : req;
  endfunction

  // base and offset are both below ring
  function automatic logic [31:0] ring_wrap(input logic [31:0] base, input logic [31:0] off,
                                            input logic [31:0] ring);
    logic [31:0] sum;
    sum = base + off;
    return (sum >= ring) ? sum - ring : sum;
  endfunction

endpackage

// File: rtl/roi_wptr.sv
module roi_wptr #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] wpos
);
  always_ff @(posedge clk) begin
    if (!rst_n)   wpos <= '0;
    else if (adv) wpos <= (wpos + AW'(1)) & mask;
  end
endmodule

// File: rtl/roi_rdseq.sv
module roi_rdseq
  import roi_pkg::*;
#(
  parameter int AW = 13,
  parameter int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] ring,
  input  logic [LW-1:0] count,
  output logic [AW-1:0] addr,
  output logic          vld,
  output logic          first,
  output logic          last_step
);
  logic [LW-1:0] rcnt;
  logic          first_q;

  assign last_step = step && (rcnt == count - LW'(1));
  assign first     = vld && first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt    <= '0;
      addr    <= '0;
      vld     <= 1'b0;
      first_q <= 1'b0;
    end else begin
      vld <= 1'b0;
      if (load) begin
        rcnt <= '0;
      end else if (step) begin
        addr    <= AW'(ring_wrap(32'(base), 32'(rcnt), 32'(ring)));
        vld     <= 1'b1;
        first_q <= (rcnt == '0);
        rcnt    <= rcnt + LW'(1);
      end
    end
  end
endmodule

// File: rtl/roi_sampler.sv
module roi_sampler
  import roi_pkg::*;
#(
  parameter int CELLS = 1024,
  parameter int CHANS = 8,
  parameter int DW    = 10,
  localparam int AW   = $clog2(CELLS * CHANS),
  localparam int LW   = AW + 1,
  localparam int MW   = $clog2($clog2(CHANS) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic          trig,
  input  logic          arm,
  input  logic [MW-1:0] casc_mode,
  input  logic [DW-1:0] trig_dly,
  input  logic [LW-1:0] roi_len,
  input  logic          rd_tick,
  output logic [AW-1:0] stop_cell,
  output logic [AW-1:0] rd_addr,
  output logic          rd_vld,
  output logic          busy
);
  roi_state_e    state;
  logic [DW-1:0] dcnt;
  logic [LW-1:0] ring_now, ring_q, roi_q;
  logic [AW-1:0] wpos;

  // named events for the checker
  logic trig_acc, stop_evt, frozen, adv, rd_step, rd_last, rd_first;

  assign ring_now = LW'(ring_cells(32'(CELLS), 2'(casc_mode)));
  assign trig_acc = (state == ST_SAMPLE) && trig;
  assign stop_evt = (state == ST_DELAY) && (dcnt == '0);
  assign frozen   = (state == ST_DRAIN) || (state == ST_PARKED);
  assign adv      = smp_en && ((state == ST_SAMPLE) || ((state == ST_DELAY) && (dcnt != '0)));
  assign rd_step  = (state == ST_DRAIN) && rd_tick;
  assign busy     = (state == ST_DELAY) || (state == ST_DRAIN) || rd_vld;

  roi_wptr #(.AW(AW)) u_wptr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (adv),
    .mask (AW'(ring_now - LW'(1))),
    .wpos (wpos)
  );

  roi_rdseq #(.AW(AW), .LW(LW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (stop_evt),
    .step     (rd_step),
    .base     (stop_cell),
    .ring     (ring_q),
    .count    (roi_q),
    .addr     (rd_addr),
    .vld      (rd_vld),
    .first    (rd_first),
    .last_step(rd_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_SAMPLE;
      dcnt      <= '0;
      stop_cell <= '0;
      ring_q    <= LW'(CELLS);
      roi_q     <= LW'(CELLS);
    end else begin
      unique case (state)
        ST_SAMPLE: if (trig_acc) begin
          state <= ST_DELAY;
          dcnt  <= trig_dly;
        end
        ST_DELAY: begin
          if (stop_evt) begin
            state     <= ST_DRAIN;
            stop_cell <= wpos;
            ring_q    <= ring_now;
            roi_q     <= LW'(roi_clamp(32'(roi_len), 32'(ring_now)));
          end else if (smp_en) begin
            dcnt <= dcnt - DW'(1);
          end
        end
        ST_DRAIN:  if (rd_last) state <= ST_PARKED;
        ST_PARKED: if (arm) state <= ST_SAMPLE;
        default:   state <= ST_SAMPLE;
      endcase
    end
  end
endmodule

// File: rtl/roi_chk.sv
module roi_chk #(
  parameter int AW = 13,
  parameter int LW = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stop_evt,
  input logic          frozen,
  input logic          rd_first,
  input logic [AW-1:0] wpos,
  input logic [AW-1:0] stop_cell,
  input logic [AW-1:0] rd_addr,
  input logic [LW-1:0] ring_q,
  input logic          rd_vld,
  input logic          busy
);
  a_r4_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_evt |=> $stable(stop_cell));

  a_r3_busy_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> busy);

  a_r5_addr_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> ({1'b0, rd_addr} < ring_q));

  a_r5_first_is_stop: assert property (@(posedge clk) disable iff (!rst_n)
    rd_first |-> (rd_addr == stop_cell));

  a_r7_vld_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> busy);

  a_r7_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(rd_vld));

  a_r10_ring_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(wpos));
endmodule

bind roi_sampler roi_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stop_evt (stop_evt),
  .frozen   (frozen),
  .rd_first (rd_first),
  .wpos     (wpos),
  .stop_cell(stop_cell),
  .rd_addr  (rd_addr),
  .ring_q   (ring_q),
  .rd_vld   (rd_vld),
  .busy     (busy)
);

// File: tb/sim_roi_sampler.sv
module sim_roi_sampler;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_en = 1'b0, trig = 1'b0, arm = 1'b0, rd_tick = 1'b0;
  logic [1:0]  casc_mode = '0;
  logic [9:0]  trig_dly = '0;
  logic [13:0] roi_len = '0;
  logic [12:0] stop_cell, rd_addr;
  logic        rd_vld, busy;

  int n_chk = 0, n_bad = 0;
  int exp_pos = 0;

  always #(CLK_NS/2) clk = ~clk;

  roi_sampler u0 (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .trig(trig), .arm(arm),
    .casc_mode(casc_mode), .trig_dly(trig_dly), .roi_len(roi_len), .rd_tick(rd_tick),
    .stop_cell(stop_cell), .rd_addr(rd_addr), .rd_vld(rd_vld), .busy(busy)
  );

  function automatic int ring_of(input int m);
    return 1024 * (1 << m);
  endfunction

  function automatic int cells_to_read(input int req, input int ring);
    if (req < 1) return ring;
    if (req > ring) return ring;
    return req;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit s, input bit t, input bit a, input bit r);
    @(negedge clk);
    smp_en = s; trig = t; arm = a; rd_tick = r;
    @(posedge clk);
    #1;
  endtask

  task automatic ev(input int mode, input int dly, input int roi, input int nrun);
    int len, elen, k;
    bit s, r;
    len  = ring_of(mode);
    elen = cells_to_read(roi, len);
    casc_mode = 2'(mode); trig_dly = 10'(dly); roi_len = 14'(roi);
    for (int i = 0; i < nrun; i++) begin
      s = ($urandom % 4) != 0;
      step(s, 1'b0, 1'b0, $urandom % 2);     // R8: rd_tick while sampling
      if (s) exp_pos = (exp_pos + 1) % len;  // R2
      if (i == nrun - 1) chk(busy == 1'b0 && rd_vld == 1'b0, "R8 idle", busy, 0);
    end
    step(1'b1, 1'b1, 1'b0, 1'b0);
    exp_pos = (exp_pos + 1) % len;
    chk(busy == 1'b1, "R3 busy after trig", busy, 1);
    k = 0;
    while (k < dly) begin
      s = $urandom % 2;
      step(s, $urandom % 2, $urandom % 2, 1'b0);   // R8/R9 ignored in delay
      if (s) begin k++; exp_pos = (exp_pos + 1) % len; end
    end
    step($urandom % 2, $urandom % 2, 1'b0, 1'b0);
    chk(stop_cell == 13'(exp_pos), "R3 stop cell", stop_cell, exp_pos);
    chk(busy == 1'b1, "R3 busy in readout", busy, 1);
    k = 0;
    while (k < elen) begin
      r = $urandom % 2;
      step(1'b1, $urandom % 2, $urandom % 2, r);
      if (r) begin
        chk(rd_vld == 1'b1 && rd_addr == 13'((exp_pos + k) % len), "R5 R6 address",
            rd_addr, (exp_pos + k) % len);
        k++;
      end else begin
        chk(rd_vld == 1'b0, "R5 idle tick", rd_vld, 0);
      end
    end
    step(1'b1, 1'b1, 1'b0, 1'b1);
    chk(busy == 1'b0 && rd_vld == 1'b0, "R7 R6 end of region", busy, 0);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b1, 1'b0, 1'b1);
      chk(busy == 1'b0 && rd_vld == 1'b0, "R8 trig parked", busy, 0);
    end
    chk(stop_cell == 13'(exp_pos), "R4 stop held", stop_cell, exp_pos);
    step(1'b1, 1'b0, 1'b1, 1'b0);   // R9 arm; R10 position unchanged
    chk(stop_cell == 13'(exp_pos), "R4 stop after arm", stop_cell, exp_pos);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(rd_vld == 1'b0, "R1 vld", rd_vld, 0);
    chk(stop_cell == 13'd0, "R1 stop", stop_cell, 0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_pos = 0;
    ev(0, 0, 5, 0);        // R1: stop at 1 proves start at 0
    ev(1, 3, 0, 10);       // R6 zero length, R2 2048 ring
    ev(3, 0, 9000, 0);     // R6 oversize, R10 no motion across readout
    ev(0, 5, 1024, 2);     // R6 exact ring length, R2 wrap to 1024
    ev(2, 1, 1, 0);        // R6 single cell
    for (int n = 0; n < 10; n++)
      ev($urandom % 4, $urandom % 60, $urandom % 400, $urandom % 3000);
    ev(0, 2, 1023, 5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule